// File: doc/BRIEF.md
# Interleaved ADC Slot Sequencer

This block paces a single shared successive-approximation converter. It runs on the converter clock (nominally 10 MHz) and cuts time into fixed slots of 20 cycles. Each slot begins with 4 cycles of sample-and-hold, then 16 cycles of conversion. During the first 12 conversion cycles a bit-serial search register resolves one result bit per cycle, MSB first. The analog side is outside the block: it receives a trial code and returns a single comparator bit. The last 4 conversion cycles are left for settling.

Slots for the external inputs alternate with a slot for an internal channel. The order is external 0, internal, external 1, internal, external 2, internal, external 3, internal. This frame of eight slots lasts 160 cycles (16 µs at 10 MHz), so each external input is converted 62.5 thousand times per second. When a slot ends, its 12-bit result leaves with a one-cycle valid pulse and a tag that names the channel. An enable input starts and stops the sequence. Stopping is immediate, and each restart begins a fresh frame.

Top module: `adc_slot_seq`

## Requirements
- R1: While `enable` is low, `sample_hold`, `conv_active` and `res_valid` are 0, and `chan_sel` and `dac_code` are 0. This includes the state right after reset.
- R2: While enabled, every slot is 20 cycles long. `sample_hold` is high for exactly its first 4 cycles and `conv_active` for exactly the next 16. The two are never high together.
- R3: The channel code on `chan_sel` follows the slot order 0, 4, 1, 4, 2, 4, 3, 4 and then repeats. Codes 0 to 3 name the external inputs and code 4 the internal channel. The frame is 160 cycles long, so each external code returns every 160 cycles.
- R4: `chan_sel` stays constant through all 20 cycles of a slot. It may change only when one slot ends and the next begins.
- R5: In conversion cycle k (k = 0..11), `dac_code` equals the bits already decided with bit 11-k also set. A comparator value of 1 (`cmp_in`) keeps that bit and 0 clears it, so the final code is the largest 12-bit value the comparator accepts.
- R6: In the first cycle after a slot ends, `res_valid` is high for one cycle. `res_data` then carries that slot's 12-bit result and `res_tag` carries that slot's channel code.
- R7: Taking `enable` low forces all outputs to idle in that same cycle. A slot in progress is dropped, and no `res_valid` pulse follows for it.
- R8: Raising `enable` starts at external channel 0 in the first sampling cycle. In that cycle `sample_hold` is 1 and `chan_sel` is 0.
- R9: The extreme inputs 0 and 4095 resolve exactly. So do the alternating patterns 0xAAA and 0x555.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the slot sequence while high |
| cmp_in | input | 1 | Comparator decision: input is at or above `dac_code` |
| chan_sel | output | 3 | Channel code of the current slot (0-3 external, 4 internal) |
| sample_hold | output | 1 | High during the sampling phase |
| conv_active | output | 1 | High during the conversion phase |
| dac_code | output | 12 | Trial code for the comparator's reference DAC |
| res_valid | output | 1 | One-cycle pulse when a result is presented |
| res_data | output | 12 | Converted value |
| res_tag | output | 3 | Channel code of the presented result |

## Verification
A comparator model answers from a distinct input level for each channel. A mid-scale set with a different value on every channel shows whether results land with the correct tag and slot order. The extremes 0 and 4095 test the search at each end of the range, and the 0xAAA/0x555 pair checks that every bit position is decided independently. Dropping `enable` in mid-conversion and again on the last cycle of a slot separates a clean abort from a stale result pulse. The restart that follows checks that the frame begins again at external channel 0.

// File: rtl/adc_seq_pkg.sv
// Shared types for the interleaved ADC slot sequencer.
package adc_seq_pkg;
    // Phase of the current slot as seen by the analog front end.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SAMPLE  = 2'd1,
        PH_CONVERT = 2'd2
    } phase_e;
endpackage

// File: rtl/adc_slot_timer.sv
// Slot timer: counts cycles inside a slot and slots inside a frame.
// Assumes the enable input is synchronous; a low enable clears both counters
// in the next edge, while the phase output is forced idle combinationally.
module adc_slot_timer
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_CYC = 4,
    parameter int CONV_CYC   = 16,
    parameter int RES_BITS   = 12,
    parameter int NUM_SLOTS  = 8,
    localparam int SLOT_CYC  = SAMPLE_CYC + CONV_CYC,
    localparam int CW        = $clog2(SLOT_CYC),
    localparam int SW        = $clog2(NUM_SLOTS),
    localparam int BW        = $clog2(RES_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    output phase_e        phase,
    output logic [SW-1:0] slot_idx,
    output logic          bit_valid,
    output logic [BW-1:0] bit_idx,
    output logic          sample_end,
    output logic          slot_last
);
    logic [CW-1:0] cyc_q;
    logic [SW-1:0] slot_q;
    logic [CW-1:0] conv_ofs;

    // Advance the cycle counter and wrap into the next slot of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cyc_q  <= '0;
            slot_q <= '0;
        end else if (cyc_q == CW'(SLOT_CYC - 1)) begin
            cyc_q  <= '0;
            slot_q <= (slot_q == SW'(NUM_SLOTS - 1)) ? '0 : slot_q + 1'b1;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Decode phase, bit-decision window and slot markers from the counters.
    always_comb begin
        conv_ofs   = cyc_q - CW'(SAMPLE_CYC);
        if (!enable)
            phase = PH_IDLE;
        else if (cyc_q < CW'(SAMPLE_CYC))
            phase = PH_SAMPLE;
        else
            phase = PH_CONVERT;
        bit_valid  = enable && (cyc_q >= CW'(SAMPLE_CYC))
                     && (cyc_q < CW'(SAMPLE_CYC + RES_BITS));
        bit_idx    = BW'(RES_BITS - 1) - BW'(conv_ofs);
        sample_end = enable && (cyc_q == CW'(SAMPLE_CYC - 1));
        slot_last  = enable && (cyc_q == CW'(SLOT_CYC - 1));
        slot_idx   = slot_q;
    end
endmodule

// File: rtl/adc_chan_rotator.sv
// Channel rotator: maps the slot index to a channel code. Even slots visit
// the external inputs in ascending order, odd slots the internal channel.
// Assumes the frame holds exactly two slots per external input.
module adc_chan_rotator #(
    parameter int NUM_EXT   = 4,
    parameter int TAG_W     = 3,
    localparam int NUM_SLOTS = 2 * NUM_EXT,
    localparam int SW        = $clog2(NUM_SLOTS)
) (
    input  logic             enable,
    input  logic [SW-1:0]    slot_idx,
    output logic [TAG_W-1:0] chan_sel
);
    logic [TAG_W-1:0] slot_map [NUM_SLOTS];

    // Build the slot-to-channel map, one entry per slot of the frame.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_map
        if (s % 2 == 0) begin : g_ext
            assign slot_map[s] = TAG_W'(s / 2);
        end else begin : g_int
            assign slot_map[s] = TAG_W'(NUM_EXT);
        end
    end

    // Select the channel of the current slot, code 0 while idle.
    always_comb begin
        chan_sel = enable ? slot_map[slot_idx] : '0;
    end
endmodule

// File: rtl/adc_sar_engine.sv
// Bit-serial successive-approximation register. Clears at the end of the
// sampling phase, then decides one bit per enabled bit cycle, MSB first.
// Assumes cmp_in is 1 when the held input is at or above dac_code.
module adc_sar_engine #(
    parameter int RES_BITS = 12,
    localparam int BW      = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                clear,
    input  logic                converting,
    input  logic                bit_valid,
    input  logic [BW-1:0]       bit_idx,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result
);
    logic [RES_BITS-1:0] code_q;
    logic [RES_BITS-1:0] trial;

    // Form the trial code: decided bits plus the bit under test.
    always_comb begin
        trial = code_q | (RES_BITS'(1) << bit_idx);
        if (bit_valid)
            dac_code = trial;
        else if (converting)
            dac_code = code_q;
        else
            dac_code = '0;
        result = code_q;
    end

    // Keep the tested bit when the comparator accepts the trial.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            code_q <= '0;
        else if (clear)
            code_q <= '0;
        else if (bit_valid && cmp_in)
            code_q <= trial;
    end
endmodule

// File: rtl/adc_result_tagger.sv
// Result tagger: latches the finished code and its channel on the last cycle
// of a slot and shows them for one cycle. Assumes the channel is stable for
// the slot. The pulse is masked at once when enable drops.
module adc_result_tagger #(
    parameter int RES_BITS = 12,
    parameter int TAG_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                slot_last,
    input  logic [RES_BITS-1:0] result,
    input  logic [TAG_W-1:0]    chan,
    output logic                res_valid,
    output logic [RES_BITS-1:0] res_data,
    output logic [TAG_W-1:0]    res_tag
);
    logic valid_q;

    // Capture result and tag at slot end; the pulse lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            res_data <= '0;
            res_tag  <= '0;
        end else if (!enable) begin
            valid_q  <= 1'b0;
        end else begin
            valid_q <= slot_last;
            if (slot_last) begin
                res_data <= result;
                res_tag  <= chan;
            end
        end
    end

    // Mask the pulse in the cycle enable is removed.
    always_comb begin
        res_valid = valid_q && enable;
    end
endmodule

// File: rtl/adc_slot_seq.sv
// Interleaved ADC slot sequencer top. Ties the slot timer, channel rotator,
// SAR engine and result tagger together. Assumes one clock domain, the
// converter clock, and a comparator answering within the same cycle.
module adc_slot_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_EXT    = 4,
    parameter int SAMPLE_CYC = 4,
    parameter int CONV_CYC   = 16,
    parameter int RES_BITS   = 12,
    parameter int TAG_W      = 3,
    localparam int NUM_SLOTS = 2 * NUM_EXT,
    localparam int SW        = $clog2(NUM_SLOTS),
    localparam int BW        = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                cmp_in,
    output logic [TAG_W-1:0]    chan_sel,
    output logic                sample_hold,
    output logic                conv_active,
    output logic [RES_BITS-1:0] dac_code,
    output logic                res_valid,
    output logic [RES_BITS-1:0] res_data,
    output logic [TAG_W-1:0]    res_tag
);
    phase_e              phase;
    logic [SW-1:0]       slot_idx;
    logic                bit_valid;
    logic [BW-1:0]       bit_idx;
    logic                sample_end;
    logic                slot_last;
    logic [RES_BITS-1:0] sar_result;

    adc_slot_timer #(
        .SAMPLE_CYC (SAMPLE_CYC),
        .CONV_CYC   (CONV_CYC),
        .RES_BITS   (RES_BITS),
        .NUM_SLOTS  (NUM_SLOTS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .phase      (phase),
        .slot_idx   (slot_idx),
        .bit_valid  (bit_valid),
        .bit_idx    (bit_idx),
        .sample_end (sample_end),
        .slot_last  (slot_last)
    );

    adc_chan_rotator #(
        .NUM_EXT  (NUM_EXT),
        .TAG_W    (TAG_W)
    ) u_rotator (
        .enable   (enable),
        .slot_idx (slot_idx),
        .chan_sel (chan_sel)
    );

    // Drive the analog phase controls from the decoded phase.
    always_comb begin
        sample_hold = (phase == PH_SAMPLE);
        conv_active = (phase == PH_CONVERT);
    end

    adc_sar_engine #(
        .RES_BITS   (RES_BITS)
    ) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .clear      (sample_end),
        .converting (conv_active),
        .bit_valid  (bit_valid),
        .bit_idx    (bit_idx),
        .cmp_in     (cmp_in),
        .dac_code   (dac_code),
        .result     (sar_result)
    );

    adc_result_tagger #(
        .RES_BITS  (RES_BITS),
        .TAG_W     (TAG_W)
    ) u_tagger (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .slot_last (slot_last),
        .result    (sar_result),
        .chan      (chan_sel),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_tag   (res_tag)
    );
endmodule

// File: rtl/adc_slot_seq_checker.sv
// Property checker for the slot sequencer, bound to every adc_slot_seq.
// Phase lengths are measured with run counters rather than long delays.
module adc_slot_seq_checker #(
    parameter int NUM_EXT    = 4,
    parameter int SAMPLE_CYC = 4,
    parameter int CONV_CYC   = 16,
    parameter int TAG_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [TAG_W-1:0] chan_sel,
    input logic             sample_hold,
    input logic             conv_active,
    input logic             res_valid,
    input logic [TAG_W-1:0] res_tag
);
    int unsigned sh_run;
    int unsigned cv_run;

    // Count consecutive cycles of each phase strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_run <= 0;
            cv_run <= 0;
        end else begin
            sh_run <= sample_hold ? sh_run + 1 : 0;
            cv_run <= conv_active ? cv_run + 1 : 0;
        end
    end

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!sample_hold && !conv_active && !res_valid && chan_sel == '0));

    assert_phase_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_hold && conv_active));

    assert_sample_len_R2: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        $fell(sample_hold) |-> (sh_run == SAMPLE_CYC && conv_active));

    assert_conv_len_R2: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        $fell(conv_active) |-> (cv_run == CONV_CYC && sample_hold));

    assert_tag_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_tag <= TAG_W'(NUM_EXT)));

    assert_chan_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_active |-> $stable(chan_sel));

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_tag_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_tag == $past(chan_sel)));

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |-> (sample_hold && chan_sel == '0));
endmodule

bind adc_slot_seq adc_slot_seq_checker #(
    .NUM_EXT     (NUM_EXT),
    .SAMPLE_CYC  (SAMPLE_CYC),
    .CONV_CYC    (CONV_CYC),
    .TAG_W       (TAG_W)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .chan_sel    (chan_sel),
    .sample_hold (sample_hold),
    .conv_active (conv_active),
    .res_valid   (res_valid),
    .res_tag     (res_tag)
);

// File: tb/adc_slot_seq_bench.sv
`timescale 1ns/1ps
// Directed bench: a comparator model answers from a per-channel input level.
module adc_slot_seq_bench;
    localparam int CLK_PERIOD = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cmp_in;
    logic [2:0]  chan_sel;
    logic        sample_hold;
    logic        conv_active;
    logic [11:0] dac_code;
    logic        res_valid;
    logic [11:0] res_data;
    logic [2:0]  res_tag;

    logic [11:0] ain [8];
    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Comparator model: input at or above trial code.
    assign cmp_in = (ain[chan_sel] >= dac_code);

    adc_slot_seq u_adc_slot_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .cmp_in      (cmp_in),
        .chan_sel    (chan_sel),
        .sample_hold (sample_hold),
        .conv_active (conv_active),
        .dac_code    (dac_code),
        .res_valid   (res_valid),
        .res_data    (res_data),
        .res_tag     (res_tag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int slot_chan(input int s);
        return (s % 2 == 1) ? 4 : (s % 8) / 2;
    endfunction

    task automatic check_idle(input string req);
        check(!sample_hold, {req, " sample_hold"}, int'(sample_hold), 0);
        check(!conv_active, {req, " conv_active"}, int'(conv_active), 0);
        check(!res_valid,   {req, " res_valid"},   int'(res_valid), 0);
        check(chan_sel == 0, {req, " chan_sel"},   int'(chan_sel), 0);
        check(dac_code == 0, {req, " dac_code"},   int'(dac_code), 0);
    endtask

    // Check every cycle of a run started at a negedge with enable just raised.
    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            int c = i % 20;
            int s = (i / 20) % 8;
            int ch = slot_chan(s);
            #1;
            check(sample_hold == (c < 4),  "R2 sample_hold", int'(sample_hold), int'(c < 4));
            check(conv_active == (c >= 4), "R2 conv_active", int'(conv_active), int'(c >= 4));
            check(chan_sel == 3'(ch), "R3 R4 chan_sel", int'(chan_sel), ch);
            if (c >= 4 && c < 16) begin
                int k = c - 4;
                logic [11:0] prefix = ain[ch] & ~(12'hFFF >> k);
                logic [11:0] trial = prefix | (12'h800 >> k);
                check(dac_code == trial, "R5 dac_code", int'(dac_code), int'(trial));
            end
            if (c == 0 && i >= 20) begin
                int pch = slot_chan((i / 20 - 1) % 8);
                check(res_valid, "R6 res_valid", int'(res_valid), 1);
                check(res_tag == 3'(pch), "R6 res_tag", int'(res_tag), pch);
                check(res_data == ain[pch], "R6 R9 res_data", int'(res_data), int'(ain[pch]));
            end else begin
                check(!res_valid, "R6 no pulse", int'(res_valid), 0);
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        #1;
        check_idle("R1 reset");
        rst_n = 1'b1;
        @(negedge clk); #1;
        check_idle("R1 disabled");
        @(negedge clk);
    endtask

    task automatic t_main;
        ain[0] = 12'd1234; ain[1] = 12'd2047; ain[2] = 12'd3001;
        ain[3] = 12'd77;   ain[4] = 12'd2600;
        enable = 1'b1;
        // Two full frames plus one pulse: R3 frame repeat every 160 cycles.
        run_cycles(321);
        enable = 1'b0;
        #1; check_idle("R7 stop");
        @(negedge clk);
    endtask

    task automatic t_boundary;
        ain[0] = 12'd0;    ain[1] = 12'd4095; ain[2] = 12'hAAA;
        ain[3] = 12'h555;  ain[4] = 12'd4095;
        enable = 1'b1;
        run_cycles(161);
        enable = 1'b0;
        #1; check_idle("R9 stop");
        @(negedge clk);
    endtask

    task automatic t_enable_drop;
        ain[0] = 12'd500; ain[1] = 12'd1500; ain[2] = 12'd2500;
        ain[3] = 12'd3500; ain[4] = 12'd100;
        enable = 1'b1;
        run_cycles(47);
        enable = 1'b0;
        #1; check_idle("R7 mid-conversion");
        @(negedge clk); #1;
        check_idle("R7 after drop");
        @(negedge clk);
        // Drop on the last cycle of a slot: its result must not appear.
        enable = 1'b1;
        run_cycles(19);
        enable = 1'b0;
        #1; check_idle("R7 slot end");
        @(negedge clk); #1;
        check(!res_valid, "R7 stale pulse", int'(res_valid), 0);
        @(negedge clk);
        enable = 1'b1;
        #1;
        check(sample_hold && chan_sel == 0, "R8 restart", int'(chan_sel), 0);
        run_cycles(170);
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) ain[i] = '0;
        @(negedge clk);
        t_reset();
        t_main();
        t_boundary();
        t_enable_drop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule